// File: doc/BRIEF.md
# Flash Read Wait-State Controller

This block stands between a bus-side read request and the read port of a flash array. It works out how many clock cycles each read must stall and signals completion with a one-cycle ready strobe that carries the read data. A small control register selects where the wait count comes from: a programmed count, or an automatic count derived at elaboration from the clock period and the array access time. An optional extra address wait state can be added to either.

The block keeps a one-line read buffer holding the most recently fetched flash line. A request whose line address matches the buffered line is a buffer hit and is served from the buffer. Hits normally return with no wait states. In deterministic mode they instead take exactly as long as a programmed flash access, so the read latency does not depend on the buffer contents. A privileged-only flag restricts control register access to requests that carry the privilege attribute.

Top module: `flash_wait_ctl`

## Requirements
- R1: After reset the control register reads 0x00008000 (automatic waits on, all else zero), the block is idle, and rdReady, rdData, cfgErr and cfgRdata are zero.
- R2: Only bit 2 (privileged-only), bits 11:8 (programmed count), bit 14 (address wait), bit 15 (automatic mode) and bits 19:16 (buffer mode) are stored. All other bits read back as zero, so writing all ones reads back 0x000FCF04.
- R3: While bit 2 is set, a register access with cfgPriv low is refused. The register is unchanged, cfgRdata stays zero and cfgErr is high for the single cycle after the access. While bit 2 is clear, both kinds of access are served.
- R4: With bit 15 clear, a flash access (buffer miss) waits bit14 + bits[11:8] cycles. This covers 0 up to 16 cycles.
- R5: With bit 15 set, a flash access waits bit14 + AUTO_WS cycles, where AUTO_WS = ceil((ACCESS_PS + 5000) / CLK_PERIOD_PS) + 2. This is 10 at the default parameters.
- R6: A buffer hit has zero wait states when the buffer mode field bits 19:16 holds any value other than 1.
- R7: With buffer mode 1 and bit 15 clear, a buffer hit waits bit14 + bits[11:8] cycles.
- R8: With buffer mode 1 and bit 15 set, a buffer hit has zero wait states.
- R9: For a request accepted at clock edge k with W wait states, rdReady and rdData are valid together for exactly one cycle, starting at edge k+W+1. rdData is zero in every other cycle.
- R10: A request is accepted only while rdIdle is high. A request raised while busy is ignored and does not start a new access.
- R11: The wait count is fixed when a request is accepted. Rewriting the register during the wait does not change that request's latency.
- R12: A request hits if its line address (rdAddr above the word-select bits) equals the line filled by the last completed miss. The returned word is the addressed word of that line. A miss drives the line address on flashAddr for the whole wait, returns the word sampled from flashRdata, and loads the line into the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgValid | input | 1 | Register access strobe |
| cfgWrite | input | 1 | 1 = write, 0 = read |
| cfgPriv | input | 1 | Access carries the privilege attribute |
| cfgWdata | input | 32 | Register write data |
| cfgRdata | output | 32 | Register read data, one cycle after a served read, else zero |
| cfgErr | output | 1 | One-cycle refusal response |
| rdReq | input | 1 | Read request, taken while idle |
| rdAddr | input | ADDR_W | Word address of the read |
| rdIdle | output | 1 | Block can accept a request |
| rdReady | output | 1 | Read complete, data valid |
| rdData | output | DATA_W | Read data |
| flashAddr | output | ADDR_W-log2(LINE_WORDS) | Line address presented to the array |
| flashRdata | input | DATA_W*LINE_WORDS | Line returned by the array |

## Verification
The assertions assume that the flash line on flashRdata is a stable function of flashAddr during a wait. They also assume that cfgValid and rdReq are sampled only as single, well-formed pulses: no X values, and no reliance on what happens to a request raised while the block is busy beyond its being dropped. The stimulus drives inputs only at falling edges. It derives flash data combinationally from flashAddr, keeps each register access to one cycle, and raises overlapping requests only in the test that checks they are ignored. A behavioural model updated on every rising edge predicts all outputs, and the outputs are compared at each falling edge.

// File: rtl/fwc_pkg.sv
package fwc_pkg;

  localparam logic [31:0] CTRL_RESET = 32'h0000_8000;
  localparam logic [31:0] CTRL_MASK  = 32'h000F_CF04;

  typedef struct packed {
    logic [3:0] bufMode;
    logic       autoWs;
    logic       adrWs;
    logic [3:0] fws;
    logic       privOnly;
  } fwc_ctrl_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RESP = 2'd2
  } fwc_state_t;

  typedef struct packed {
    logic accept;
    logic tick;
    logic finish;
    logic cfgWr;
    logic cfgRd;
    logic cfgDeny;
  } fwc_strobe_t;

  function automatic fwc_ctrl_t ctrlFromWord(input logic [31:0] w);
    fwc_ctrl_t c;
    c.bufMode  = w[19:16];
    c.autoWs   = w[15];
    c.adrWs    = w[14];
    c.fws      = w[11:8];
    c.privOnly = w[2];
    return c;
  endfunction

  function automatic logic [31:0] ctrlToWord(input fwc_ctrl_t c);
    logic [31:0] w;
    w        = '0;
    w[19:16] = c.bufMode;
    w[15]    = c.autoWs;
    w[14]    = c.adrWs;
    w[11:8]  = c.fws;
    w[2]     = c.privOnly;
    return w;
  endfunction

  function automatic int unsigned autoCycles(input int unsigned clkPs,
                                             input int unsigned accPs);
    return (accPs + 5000 + clkPs - 1) / clkPs + 2;
  endfunction

endpackage

// File: rtl/fwc_control.sv
module fwc_control
  import fwc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgValid,
  input  logic        cfgWrite,
  input  logic        cfgPriv,
  input  logic        privOnly,
  input  logic        rdReq,
  input  logic        cntZero,
  output fwc_strobe_t stb,
  output logic        rdIdle,
  output logic        rdReady,
  output logic        cfgErr
);

  fwc_state_t state, stateNext;
  logic       allowed;

  assign allowed = !privOnly || cfgPriv;

  always_comb begin
    stb         = '0;
    stb.accept  = (state == ST_IDLE) && rdReq;
    stb.tick    = (state == ST_WAIT) && !cntZero;
    stb.finish  = (state == ST_WAIT) && cntZero;
    stb.cfgWr   = cfgValid && cfgWrite && allowed;
    stb.cfgRd   = cfgValid && !cfgWrite && allowed;
    stb.cfgDeny = cfgValid && !allowed;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (stb.accept) stateNext = ST_WAIT;
      ST_WAIT: if (stb.finish) stateNext = ST_RESP;
      ST_RESP: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      rdReady <= 1'b0;
      cfgErr  <= 1'b0;
    end else begin
      state   <= stateNext;
      rdReady <= stb.finish;
      cfgErr  <= stb.cfgDeny;
    end
  end

  assign rdIdle = (state == ST_IDLE);

  // R9: completion strobe lasts one cycle
  a_r9_ready_single: assert property (@(posedge clk) disable iff (!rstN)
    rdReady |=> !rdReady);

  // R10: a pending wait is never abandoned by a new request
  a_r10_busy_hold: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && !cntZero) |=> (state == ST_WAIT));

  // R10: busy cycles never reopen acceptance mid-wait
  a_r10_not_idle: assert property (@(posedge clk) disable iff (!rstN)
    rdReady |-> !rdIdle);

  // R3: error only follows an unprivileged access under the privilege flag
  a_r3_err_source: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |-> $past(cfgValid && privOnly && !cfgPriv));

endmodule

// File: rtl/fwc_datapath.sv
module fwc_datapath
  import fwc_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int WORDS   = 4,
  parameter int AUTO_WS = 10
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  fwc_strobe_t               stb,
  input  logic [31:0]               cfgWdata,
  input  logic [ADDR_W-1:0]         rdAddr,
  input  logic [DATA_W*WORDS-1:0]   flashRdata,
  output logic                      privOnly,
  output logic                      cntZero,
  output logic [ADDR_W-$clog2(WORDS)-1:0] flashAddr,
  output logic [DATA_W-1:0]         rdData,
  output logic [31:0]               cfgRdata
);

  localparam int WB     = $clog2(WORDS);
  localparam int LW     = ADDR_W - WB;
  localparam int LINE_W = DATA_W * WORDS;
  localparam int MAXW   = ((AUTO_WS > 15) ? AUTO_WS : 15) + 1;
  localparam int CW     = $clog2(MAXW + 1);

  fwc_ctrl_t         ctrlReg;
  logic [CW-1:0]     cnt;
  logic [LW-1:0]     lineReg;
  logic [WB-1:0]     wordReg;
  logic              hitReg;
  logic              bufValid;
  logic [LW-1:0]     bufTag;
  logic [LINE_W-1:0] bufLine;

  logic [DATA_W-1:0] bufWords   [WORDS];
  logic [DATA_W-1:0] flashWords [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : gSplit
    assign bufWords[g]   = bufLine[g*DATA_W +: DATA_W];
    assign flashWords[g] = flashRdata[g*DATA_W +: DATA_W];
  end

  // wait-count selection
  logic [CW-1:0] adrCnt, progCnt, autoCnt, flashWait, hitWait;
  logic          detOn, reqHit;
  logic [LW-1:0] reqLine;

  always_comb begin
    adrCnt    = CW'(ctrlReg.adrWs);
    progCnt   = CW'(ctrlReg.fws);
    autoCnt   = CW'(AUTO_WS);
    flashWait = adrCnt + (ctrlReg.autoWs ? autoCnt : progCnt);
    detOn     = (ctrlReg.bufMode == 4'd1) && !ctrlReg.autoWs;
    hitWait   = detOn ? (adrCnt + progCnt) : '0;
  end

  assign reqLine = rdAddr[ADDR_W-1:WB];
  assign reqHit  = bufValid && (bufTag == reqLine);
  assign cntZero = (cnt == '0);

  // control register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg  <= ctrlFromWord(CTRL_RESET);
      cfgRdata <= '0;
    end else begin
      if (stb.cfgWr) ctrlReg <= ctrlFromWord(cfgWdata);
      cfgRdata <= stb.cfgRd ? ctrlToWord(ctrlReg) : '0;
    end
  end

  assign privOnly = ctrlReg.privOnly;

  // request capture and wait counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      lineReg <= '0;
      wordReg <= '0;
      hitReg  <= 1'b0;
    end else if (stb.accept) begin
      cnt     <= reqHit ? hitWait : flashWait;
      lineReg <= reqLine;
      wordReg <= rdAddr[WB-1:0];
      hitReg  <= reqHit;
    end else if (stb.tick) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign flashAddr = lineReg;

  // read buffer and returned data
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufValid <= 1'b0;
      bufTag   <= '0;
      bufLine  <= '0;
      rdData   <= '0;
    end else begin
      rdData <= '0;
      if (stb.finish) begin
        if (hitReg) begin
          rdData <= bufWords[wordReg];
        end else begin
          rdData   <= flashWords[wordReg];
          bufLine  <= flashRdata;
          bufTag   <= lineReg;
          bufValid <= 1'b1;
        end
      end
    end
  end

  // R3: refused access leaves the register alone
  a_r3_deny_keeps: assert property (@(posedge clk) disable iff (!rstN)
    stb.cfgDeny |=> $stable(ctrlReg));

  // R2: unimplemented bits never read back
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRdata & ~CTRL_MASK) == 32'h0);

  // R8: deterministic buffer timing is dropped under automatic mode
  a_r8_auto_hit_zero: assert property (@(posedge clk) disable iff (!rstN)
    (stb.accept && reqHit && ctrlReg.autoWs) |=> cntZero);

  // R12: a completed miss fills the buffer with its own line
  a_r12_fill_on_miss: assert property (@(posedge clk) disable iff (!rstN)
    (stb.finish && !hitReg) |=> (bufValid && bufTag == $past(lineReg)));

  // R9: data appears only right after completion
  a_r9_data_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (rdData != '0) |-> $past(stb.finish));

endmodule

// File: rtl/flash_wait_ctl.sv
module flash_wait_ctl
  import fwc_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 32,
  parameter int LINE_WORDS    = 4,
  parameter int CLK_PERIOD_PS = 4000,
  parameter int ACCESS_PS     = 25000
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                cfgValid,
  input  logic                                cfgWrite,
  input  logic                                cfgPriv,
  input  logic [31:0]                         cfgWdata,
  output logic [31:0]                         cfgRdata,
  output logic                                cfgErr,
  input  logic                                rdReq,
  input  logic [ADDR_W-1:0]                   rdAddr,
  output logic                                rdIdle,
  output logic                                rdReady,
  output logic [DATA_W-1:0]                   rdData,
  output logic [ADDR_W-$clog2(LINE_WORDS)-1:0] flashAddr,
  input  logic [DATA_W*LINE_WORDS-1:0]        flashRdata
);

  localparam int AUTO_WS = int'(autoCycles(CLK_PERIOD_PS, ACCESS_PS));

  fwc_strobe_t stb;
  logic        privOnly;
  logic        cntZero;

  fwc_control uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgValid (cfgValid),
    .cfgWrite (cfgWrite),
    .cfgPriv  (cfgPriv),
    .privOnly (privOnly),
    .rdReq    (rdReq),
    .cntZero  (cntZero),
    .stb      (stb),
    .rdIdle   (rdIdle),
    .rdReady  (rdReady),
    .cfgErr   (cfgErr)
  );

  fwc_datapath #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .WORDS   (LINE_WORDS),
    .AUTO_WS (AUTO_WS)
  ) uData (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .cfgWdata   (cfgWdata),
    .rdAddr     (rdAddr),
    .flashRdata (flashRdata),
    .privOnly   (privOnly),
    .cntZero    (cntZero),
    .flashAddr  (flashAddr),
    .rdData     (rdData),
    .cfgRdata   (cfgRdata)
  );

endmodule

// File: tb/sim_flash_wait_ctl.sv
module sim_flash_wait_ctl;

  localparam int AUTO = 10; // ceil((25000+5000)/4000)+2
  localparam logic [31:0] MASK = 32'h000F_CF04;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         cfgValid = 1'b0, cfgWrite = 1'b0, cfgPriv = 1'b0;
  logic [31:0]  cfgWdata = '0;
  logic [31:0]  cfgRdata;
  logic         cfgErr;
  logic         rdReq = 1'b0;
  logic [15:0]  rdAddr = '0;
  logic         rdIdle, rdReady;
  logic [31:0]  rdData;
  logic [13:0]  flashAddr;
  logic [127:0] flashRdata;

  always #2 clk = ~clk;

  flash_wait_ctl u0 (
    .clk(clk), .rstN(rstN), .cfgValid(cfgValid), .cfgWrite(cfgWrite),
    .cfgPriv(cfgPriv), .cfgWdata(cfgWdata), .cfgRdata(cfgRdata),
    .cfgErr(cfgErr), .rdReq(rdReq), .rdAddr(rdAddr), .rdIdle(rdIdle),
    .rdReady(rdReady), .rdData(rdData), .flashAddr(flashAddr),
    .flashRdata(flashRdata)
  );

  function automatic logic [127:0] lineOf(input logic [13:0] a);
    logic [127:0] l;
    for (int w = 0; w < 4; w++)
      l[w*32 +: 32] = 32'h5A00_0000 ^ ({16'h0, a, 2'(w)} << 4) ^ 32'(w + 1);
    return l;
  endfunction

  assign flashRdata = lineOf(flashAddr);

  int    nChecks = 0, nFail = 0;
  string curTag = "R1";

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", curTag, what, act, exp);
    end
  endtask

  // behavioural reference model
  logic [31:0]  mReg;
  int           mState, mCnt, mWord;
  logic [13:0]  mLine, mBufTag;
  bit           mHit, mBufValid, mReady, mErr;
  logic [127:0] mBufLine;
  logic [31:0]  mData, mRdata;
  bit           started = 0;

  function automatic int waitFor(input logic [31:0] r, input bit hit);
    int adr = int'(r[14]);
    if (hit) return (r[19:16] == 4'd1 && !r[15]) ? adr + int'(r[11:8]) : 0;
    return adr + (r[15] ? AUTO : int'(r[11:8]));
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mReg = 32'h0000_8000; mState = 0; mCnt = 0; mWord = 0; mLine = '0;
      mHit = 0; mBufValid = 0; mBufTag = '0; mBufLine = '0;
      mReady = 0; mErr = 0; mData = '0; mRdata = '0;
    end else begin
      logic [31:0] oldReg;
      logic [127:0] ln;
      started = 1;
      oldReg = mReg;
      mReady = 0; mData = '0; mErr = 0; mRdata = '0;
      case (mState)
        0: if (rdReq) begin
             mLine = rdAddr[15:2];
             mHit  = mBufValid && (mBufTag == mLine);
             mCnt  = waitFor(oldReg, mHit);
             mWord = int'(rdAddr[1:0]);
             mState = 1;
           end
        1: if (mCnt == 0) begin
             mState = 2; mReady = 1;
             if (mHit) mData = mBufLine[mWord*32 +: 32];
             else begin
               ln = lineOf(mLine);
               mData = ln[mWord*32 +: 32];
               mBufLine = ln; mBufTag = mLine; mBufValid = 1;
             end
           end else mCnt--;
        default: mState = 0;
      endcase
      if (cfgValid) begin
        if (oldReg[2] && !cfgPriv) mErr = 1;
        else if (cfgWrite) mReg = cfgWdata & MASK;
        else mRdata = oldReg;
      end
    end
  end

  always @(negedge clk) begin
    if (started) begin
      chk("rdIdle",   32'(rdIdle),  32'(mState == 0));
      chk("rdReady",  32'(rdReady), 32'(mReady));
      chk("rdData",   rdData,       mData);
      chk("cfgErr",   32'(cfgErr),  32'(mErr));
      chk("cfgRdata", cfgRdata,     mRdata);
      if (mState == 1) chk("flashAddr", 32'(flashAddr), 32'(mLine));
    end
  end

  // stimulus tasks
  task automatic cfgWr(input bit priv, input logic [31:0] d, input bit expErr);
    @(negedge clk);
    cfgValid = 1; cfgWrite = 1; cfgPriv = priv; cfgWdata = d;
    @(negedge clk);
    cfgValid = 0; cfgWrite = 0; cfgPriv = 0;
    chk("write error", 32'(cfgErr), 32'(expErr));
  endtask

  task automatic cfgRd(input bit priv, input logic [31:0] exp, input bit expErr);
    @(negedge clk);
    cfgValid = 1; cfgWrite = 0; cfgPriv = priv;
    @(negedge clk);
    cfgValid = 0; cfgPriv = 0;
    chk("read data", cfgRdata, exp);
    chk("read error", 32'(cfgErr), 32'(expErr));
  endtask

  task automatic doRead(input logic [15:0] a, input int expWaits);
    int n;
    logic [127:0] ln;
    @(negedge clk);
    while (!rdIdle) @(negedge clk);
    rdReq = 1; rdAddr = a;
    @(negedge clk);
    rdReq = 0;
    n = 1;
    while (!rdReady && n < 100) begin @(negedge clk); n++; end
    chk("latency", 32'(n), 32'(expWaits + 2));
    ln = lineOf(a[15:2]);
    chk("R12 word", rdData, ln[a[1:0]*32 +: 32]);
    @(negedge clk);
    chk("R9 ready one cycle", 32'(rdReady), 32'd0);
    chk("R9 data cleared", rdData, 32'd0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin : stim
    int n;
    repeat (3) @(negedge clk);
    curTag = "R1";
    chk("R1 idle in reset", 32'(rdIdle), 32'd1);
    rstN = 1;
    @(negedge clk);
    chk("R1 ready low", 32'(rdReady), 32'd0);
    cfgRd(1, 32'h0000_8000, 0);

    curTag = "R5";
    doRead(16'h0010, AUTO);
    cfgWr(1, 32'h0000_C000, 0);
    doRead(16'h0020, AUTO + 1);

    curTag = "R6";
    doRead(16'h0021, 0);

    curTag = "R4";
    cfgWr(1, 32'h0000_0300, 0);
    doRead(16'h0030, 3);
    cfgWr(1, 32'h0000_4F00, 0);
    doRead(16'h0040, 16);
    cfgWr(1, 32'h0000_0000, 0);
    doRead(16'h0050, 0);

    curTag = "R7";
    cfgWr(1, 32'h0001_4500, 0);
    doRead(16'h0052, 6);
    doRead(16'h0060, 6);

    curTag = "R8";
    cfgWr(1, 32'h0001_C500, 0);
    doRead(16'h0061, 0);
    doRead(16'h0070, AUTO + 1);

    curTag = "R6";
    cfgWr(1, 32'h0002_0500, 0);
    doRead(16'h0073, 0);

    curTag = "R2";
    cfgWr(1, 32'hFFFF_FFFF, 0);
    cfgRd(1, 32'h000F_CF04, 0);

    curTag = "R3";
    cfgWr(1, 32'h0000_0304, 0);
    cfgWr(0, 32'h0000_0000, 1);
    cfgRd(0, 32'h0000_0000, 1);
    cfgRd(1, 32'h0000_0304, 0);
    doRead(16'h0080, 3);
    cfgWr(1, 32'h0000_0300, 0);
    cfgWr(0, 32'h0000_0500, 0);
    cfgRd(0, 32'h0000_0500, 0);

    curTag = "R10";
    cfgWr(1, 32'h0000_8000, 0);
    @(negedge clk);
    rdReq = 1; rdAddr = 16'h0090;
    @(negedge clk);
    rdAddr = 16'h00A0;
    repeat (3) @(negedge clk);
    chk("R10 busy", 32'(rdIdle), 32'd0);
    rdReq = 0;
    n = 4;
    while (!rdReady && n < 100) begin @(negedge clk); n++; end
    chk("R10 latency", 32'(n), 32'(AUTO + 2));
    @(negedge clk);
    chk("R10 idle after", 32'(rdIdle), 32'd1);

    curTag = "R11";
    cfgWr(1, 32'h0000_0800, 0);
    @(negedge clk);
    rdReq = 1; rdAddr = 16'h00B0;
    @(negedge clk);
    rdReq = 0;
    cfgValid = 1; cfgWrite = 1; cfgPriv = 1; cfgWdata = 32'h0;
    @(negedge clk);
    cfgValid = 0; cfgWrite = 0; cfgPriv = 0;
    n = 2;
    while (!rdReady && n < 100) begin @(negedge clk); n++; end
    chk("R11 latency kept", 32'(n), 32'd10);

    curTag = "R12";
    doRead(16'h00B2, 0);
    doRead(16'h00C1, 0);

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule